// File: doc/BRIEF.md
# Receive FIFO Drain Engine

This block empties the receive queue of a serial channel by talking to the channel's registers through a narrow register-access port. A single-cycle start pulse launches a loop. Each pass reads the control/status register and tests its receive-ready bit. When a character is waiting, the engine reads that character's error status first and then the data byte. The status read must come first because reading the data discards the status of that character. If any error bit is set, the engine writes the error-reset command back to the control register. The data byte is thrown away; only a count of drained characters is kept.

The loop has a hard limit on the number of passes. A channel that is missing, or that always reports ready, therefore cannot hold the engine forever. When the loop ends, the engine pulses `done` for one cycle. It also reports whether the limit ended the loop, and it reports how many characters were drained and how many error resets it issued.

The state machine has six states:

- `ST_IDLE`: waits for `start`.
- `ST_POLL`: reads the control register.
- `ST_RD_ERR`: reads the error status.
- `ST_RD_DATA`: reads the data byte.
- `ST_WR_RST`: writes the reset command.
- `ST_FINISH`: raises `done`.

Its transitions are:

- `ST_IDLE` moves to `ST_POLL` when `start` is high.
- `ST_POLL` moves to `ST_RD_ERR` on ack with ready set, and to `ST_FINISH` on ack with ready clear.
- `ST_RD_ERR` moves to `ST_RD_DATA` on ack.
- `ST_RD_DATA` moves to `ST_WR_RST` on ack when the latched status had an error. Otherwise it ends the pass.
- `ST_WR_RST` ends the pass on ack.
- Ending a pass goes to `ST_FINISH` if the pass was the last one allowed, and to `ST_POLL` otherwise.
- `ST_FINISH` always moves to `ST_IDLE`.

Top module: `rx_drain_engine`

## Requirements
- R1: After reset the engine is idle: `acc_req`, `done`, `busy` and `hit_limit` are 0, and both counts are 0.
- R2: Each pass begins with a read of address 0, where bit 0 is receive-ready. If that bit is 0, the loop ends with `hit_limit` = 0.
- R3: For each waiting character, address 1 (error status) is read before address 8 (data). Exactly one status read precedes each data read.
- R4: If the status byte has bit 4 (parity), bit 5 (overrun) or bit 6 (framing) set, the engine writes 8'h30 to address 0 after the data read. No write is issued otherwise, and no other write is ever issued.
- R5: At most MAX_PASSES (32) passes are made. When the 32nd pass completes, the loop ends without another poll and `hit_limit` = 1. With exactly 31 waiting characters, the final poll finds the queue empty and `hit_limit` = 0.
- R6: A request holds `acc_req`, `acc_addr`, `acc_we` and `acc_wdata` steady until `acc_ack`, and only one access is outstanding at a time.
- R7: `done` is high for exactly one cycle at the end of each run, and `busy` is low in the cycle after it.
- R8: `chars_drained` and `err_resets` count the data reads and the reset writes of the last run. Both saturate at MAX_PASSES, are cleared when a run starts, and hold their value until the next run.
- R9: A `start` pulse while `busy` is high is ignored: the run in progress is neither restarted nor extended, and its counts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a drain run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| hit_limit | output | 1 | Last run ended on the pass limit |
| chars_drained | output | 6 | Characters read in the last run |
| err_resets | output | 6 | Error-reset commands issued in the last run |
| acc_req | output | 1 | Register access request |
| acc_we | output | 1 | Access is a write |
| acc_addr | output | 4 | Register address |
| acc_wdata | output | 8 | Write data |
| acc_ack | input | 1 | Access completed |
| acc_rdata | input | 8 | Read data, valid with `acc_ack` |

## Verification
The drain loop is exercised with the following queue contents, each separating a different fault:

- An empty queue separates a stop on an empty poll from a stop on the limit.
- Clean characters mixed with a status byte that has only a non-error bit set separate the error mask from a plain nonzero test.
- Characters with each single error bit, and with all of them, catch a missing bit in the mask.
- Queues of 31 and 32 characters, and a channel whose ready bit is stuck high, pin the limit to the exact pass and show that the limit ends a run with no extra poll.
- A start pulse during a run shows that the run is neither restarted nor counted twice.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_RD_ERR,
        ST_RD_DATA,
        ST_WR_RST,
        ST_FINISH
    } drain_state_t;

    // register map of the channel as seen by the engine
    localparam logic [3:0] CTRL_ADDR  = 4'd0;
    localparam logic [3:0] ERRST_ADDR = 4'd1;
    localparam logic [3:0] DATA_ADDR  = 4'd8;

    localparam int unsigned RDY_BIT   = 0;
    localparam logic [7:0]  ERR_MASK  = 8'h70;  // parity 4, overrun 5, framing 6
    localparam logic [7:0]  RESET_CMD = 8'h30;

endpackage

// File: rtl/rxd_sat_counter.sv
module rxd_sat_counter #(
    parameter int unsigned WIDTH = 6,
    parameter int unsigned LIMIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && q != TOP) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/rx_drain_engine.sv
module rx_drain_engine
    import rxd_pkg::*;
#(
    parameter int unsigned MAX_PASSES = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CNT_W      = $clog2(MAX_PASSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              hit_limit,
    output logic [CNT_W-1:0]  chars_drained,
    output logic [CNT_W-1:0]  err_resets,
    output logic              acc_req,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_ack,
    input  logic [DATA_W-1:0] acc_rdata
);

    localparam logic [CNT_W-1:0] LAST_PASS = CNT_W'(MAX_PASSES - 1);

    drain_state_t state_q, state_d;
    logic         err_q;
    logic         limit_q;
    logic         launch;
    logic         pass_end;
    logic         last_pass;
    logic         char_read;
    logic         rst_sent;
    logic [CNT_W-1:0] pass_cnt;

    assign launch    = (state_q == ST_IDLE) && start;
    assign char_read = (state_q == ST_RD_DATA) && acc_ack;
    assign rst_sent  = (state_q == ST_WR_RST) && acc_ack;
    assign pass_end  = (char_read && !err_q) || rst_sent;
    assign last_pass = (pass_cnt == LAST_PASS);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_POLL;
            ST_POLL:    if (acc_ack)
                            state_d = acc_rdata[RDY_BIT] ? ST_RD_ERR : ST_FINISH;
            ST_RD_ERR:  if (acc_ack) state_d = ST_RD_DATA;
            ST_RD_DATA: if (acc_ack)
                            state_d = err_q ? ST_WR_RST
                                    : (last_pass ? ST_FINISH : ST_POLL);
            ST_WR_RST:  if (acc_ack) state_d = last_pass ? ST_FINISH : ST_POLL;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and per-run flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
            limit_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RD_ERR && acc_ack)
                err_q <= |(acc_rdata & ERR_MASK);
            if (launch)
                limit_q <= 1'b0;
            else if (pass_end && last_pass)
                limit_q <= 1'b1;
        end
    end

    // outputs decoded from the state
    always_comb begin
        acc_req   = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = CTRL_ADDR;
        acc_wdata = '0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_POLL:    acc_req = 1'b1;
            ST_RD_ERR:  begin acc_req = 1'b1; acc_addr = ERRST_ADDR; end
            ST_RD_DATA: begin acc_req = 1'b1; acc_addr = DATA_ADDR;  end
            ST_WR_RST:  begin acc_req = 1'b1; acc_we = 1'b1; acc_wdata = RESET_CMD; end
            ST_FINISH:  done = 1'b1;
            default:    ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign hit_limit = limit_q;

    rxd_sat_counter #(.WIDTH(CNT_W), .LIMIT(MAX_PASSES)) u_pass_cnt (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(pass_end), .q(pass_cnt)
    );

    rxd_sat_counter #(.WIDTH(CNT_W), .LIMIT(MAX_PASSES)) u_char_cnt (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(char_read), .q(chars_drained)
    );

    rxd_sat_counter #(.WIDTH(CNT_W), .LIMIT(MAX_PASSES)) u_rst_cnt (
        .clk(clk), .rst_n(rst_n), .clr(launch), .inc(rst_sent), .q(err_resets)
    );

    // R6
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr)
                                   && $stable(acc_we) && $stable(acc_wdata)));

    // R4
    only_reset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we) |-> (acc_addr == CTRL_ADDR && acc_wdata == RESET_CMD));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5
    limit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_limit |-> (chars_drained == CNT_W'(MAX_PASSES)));

    // R8
    resets_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_resets <= chars_drained);

endmodule

// File: tb/rx_drain_engine_tb.sv
module rx_drain_engine_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, hit_limit;
    logic [5:0] chars_drained, err_resets;
    logic       acc_req, acc_we, acc_ack;
    logic [3:0] acc_addr;
    logic [7:0] acc_wdata, acc_rdata;

    int total = 0;
    int bad   = 0;

    // behavioural channel model
    logic [7:0] q_data [0:63];
    logic [7:0] q_stat [0:63];
    int  head = 0, tail = 0;
    bit  stuck = 1'b0;
    bit  stat_seen = 1'b0;
    int  polls = 0, rst_writes = 0, stray = 0, order_bad = 0, done_pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_drain_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .hit_limit(hit_limit), .chars_drained(chars_drained), .err_resets(err_resets),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ack(acc_ack), .acc_rdata(acc_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            acc_ack   <= 1'b0;
            acc_rdata <= 8'h00;
        end else if (acc_req && !acc_ack) begin
            acc_ack <= 1'b1;
            if (acc_we) begin
                if (acc_addr == 4'd0 && acc_wdata == 8'h30) rst_writes++;
                else stray++;
            end else begin
                case (acc_addr)
                    4'd0: begin
                        polls++;
                        acc_rdata <= {7'b0, (stuck || head != tail)};
                    end
                    4'd1: begin
                        if (stat_seen) order_bad++;
                        stat_seen = 1'b1;
                        acc_rdata <= (head != tail) ? q_stat[head] : 8'h00;
                    end
                    4'd8: begin
                        if (!stat_seen) order_bad++;
                        stat_seen = 1'b0;
                        acc_rdata <= (head != tail) ? q_data[head] : 8'h5A;
                        if (head != tail) head++;
                    end
                    default: stray++;
                endcase
            end
        end else begin
            acc_ack <= 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && done) done_pulses++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int n, input logic [7:0] stat_pat [4]);
        head = 0; tail = 0; polls = 0; rst_writes = 0; stray = 0;
        order_bad = 0; done_pulses = 0;
        for (int i = 0; i < n; i++) begin
            q_data[tail] = 8'(i + 8'h40);
            q_stat[tail] = stat_pat[i % 4];
            tail++;
        end
    endtask

    task automatic run_and_wait(output int cycles);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 0;
        while (!done && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
        @(negedge clk);
    endtask

    task automatic scenario(input string name, input int n, input logic [7:0] sp [4],
                            input bit stk, input int exp_chars, input int exp_rst,
                            input int exp_polls, input int exp_lim);
        int cyc;
        stuck = stk;
        load(n, sp);
        run_and_wait(cyc);
        $display("scenario %s: %0d cycles", name, cyc);
        check({"R2/R5 hit_limit ", name}, hit_limit, exp_lim);
        check({"R2/R5 polls ", name}, polls, exp_polls);
        check({"R8 chars_drained ", name}, chars_drained, exp_chars);
        check({"R8 err_resets ", name}, err_resets, exp_rst);
        check({"R4 reset writes ", name}, rst_writes, exp_rst);
        check({"R4 stray accesses ", name}, stray, 0);
        check({"R3 status-before-data ", name}, order_bad, 0);
        check({"R7 done pulses ", name}, done_pulses, 1);
        check({"R7 busy after done ", name}, busy, 0);
        stuck = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 acc_req", acc_req, 0);
        check("R1 done", done, 0);
        check("R1 busy", busy, 0);
        check("R1 hit_limit", hit_limit, 0);
        check("R1 chars_drained", chars_drained, 0);
        check("R1 err_resets", err_resets, 0);
    endtask

    task automatic test_start_while_busy();
        logic [7:0] sp [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
        int cyc;
        load(4, sp);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1;                          // R9 pulse during a run
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        repeat (3) @(negedge clk);
        check("R9 chars after busy start", chars_drained, 4);
        check("R9 single done", done_pulses, 1);
        check("R9 polls", polls, 5);
        check("R9 idle afterwards", busy, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] clean [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
        logic [7:0] mixed [4] = '{8'h00, 8'h40, 8'h01, 8'h00};
        logic [7:0] errs  [4] = '{8'h10, 8'h20, 8'h40, 8'h70};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        scenario("empty",    0,  clean, 1'b0, 0,  0, 1,  0);
        scenario("mixed",    4,  mixed, 1'b0, 4,  1, 5,  0);
        scenario("errors",   5,  errs,  1'b0, 5,  5, 6,  0);
        scenario("n31",      31, clean, 1'b0, 31, 0, 32, 0);
        scenario("n32",      32, mixed, 1'b0, 32, 8, 32, 1);
        scenario("stuck",    0,  clean, 1'b1, 32, 0, 32, 1);
        test_start_while_busy();
        scenario("rerun",    2,  errs,  1'b0, 2,  2, 3,  0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule